// File: doc/BRIEF.md
# UART Receive Data and Status Capture

This block sits between a serial receiver front end and a small register bus. Each completed character arrives with three line error indications (framing, parity, break). The block packs it into a 12-bit entry and keeps it in a 16-deep receive FIFO. When the FIFO mode input is low, it keeps it in a single holding register instead. Software drains entries by reading the data location. Each such read also copies the framing, parity and break flags of the character just taken into a separate error status register.

An arrival into a full store is an overrun. The new character is lost, and bit 11 of the newest stored entry is set. The overrun bit of the error status register is set at once, with no data read needed. Any write to the status location clears the error status register. Empty and full flags are brought out for the surrounding logic.

Bus reads are registered: the value selected at a clock edge with `bus_rd` high appears on `bus_rdata` after that edge and holds until the next read.

Top module: `rxcap_rx_capture`

## Requirements
- R1: A data read returns the oldest entry on `bus_rdata` after the same clock edge. The entry layout is character in bits [7:0], framing error at bit 8, parity error at bit 9, break at bit 10, overrun at bit 11.
- R2: With `fifo_en` high the store holds 16 entries and returns them in arrival order. `rx_full` is 0 with 15 entries stored and 1 with 16 stored.
- R3: With `fifo_en` low the store holds one entry, and `rx_full` becomes 1 after a single arrival.
- R4: An arrival while `rx_full` is 1 (and no data read in the same cycle) is discarded. Bit 11 of the newest stored entry is set.
- R5: After an overrun, bit 3 of the status read value is 1 from the next cycle, without any data read.
- R6: A status read returns {8'b0, overrun, break, parity, framing}, with framing at bit 0. Bits [2:0] change only on a data read that takes an entry, and then take that entry's flags.
- R7: Any write to the status location (`bus_wr` with `bus_sel`=1) clears all four status bits.
- R8: A data read while `rx_empty` is 1 returns the previous data-read value and changes neither flag nor any stored entry.
- R9: After reset `rx_empty`=1, `rx_full`=0, `bus_rdata`=0 and the status read value is 0.
- R10: When the store is full, a data read and an arrival in the same cycle both complete. There is no overrun, and the arrival becomes the last entry.
- R11: An overrun in the same cycle as a status write leaves the overrun status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: 16-entry FIFO, 0: single holding register |
| rx_valid | input | 1 | Front end delivers a completed character |
| rx_char | input | 8 | Received character |
| rx_frame_err | input | 1 | Framing error for this character |
| rx_parity_err | input | 1 | Parity error for this character |
| rx_break_err | input | 1 | Break condition for this character |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 1 | 0: data location, 1: status / error-clear location |
| bus_rdata | output | 12 | Registered read value |
| rx_empty | output | 1 | Store holds no entry |
| rx_full | output | 1 | Store at capacity for the current mode |

## Verification
Two pairs of operations can collide in one cycle, and the bench provokes both on purpose. First, it fills the FIFO and, at one edge, drives a data read together with a new arrival. The read must return the oldest entry and `rx_full` must stay high. The following status read must show no overrun, and the new character must come out last. Second, with the holding register full, it drives an arrival together with a status write. The status read that follows must still show the overrun bit, and the drained entry must carry bit 11.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;

    typedef struct packed {
        logic       ovr;
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic ovr;
        logic brk;
        logic par;
        logic frm;
    } rx_err_t;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_STAT = 1'b1
    } bus_sel_t;

    localparam int ENTRY_W = $bits(rx_entry_t);
    localparam int ERR_W   = $bits(rx_err_t);

    function automatic rx_entry_t make_entry(input logic [7:0] ch, input logic frm,
                                             input logic par, input logic brk);
        rx_entry_t e;
        e.ovr  = 1'b0;
        e.brk  = brk;
        e.par  = par;
        e.frm  = frm;
        e.data = ch;
        return e;
    endfunction

    function automatic rx_err_t err_of(input rx_entry_t e);
        rx_err_t r;
        r.ovr = e.ovr;
        r.brk = e.brk;
        r.par = e.par;
        r.frm = e.frm;
        return r;
    endfunction

endpackage

// File: rtl/rxcap_store.sv
module rxcap_store
    import rxcap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_en,
    input  logic      in_valid,
    input  rx_entry_t in_entry,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      pop_done,
    output logic      overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1) + 1;
    localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_CHAR = CW'(1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wptr, rptr, newest;
    logic [CW-1:0]   count, cap;
    logic            push_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign cap      = fifo_en ? CAP_FIFO : CAP_CHAR;
    assign empty    = (count == '0);
    assign full     = (count >= cap);
    assign pop_done = pop_req && !empty;
    assign push_ok  = in_valid && ((count < cap) || (pop_done && count == cap));
    assign overrun  = in_valid && !push_ok;
    assign newest   = (wptr == '0) ? AW'(DEPTH - 1) : wptr - AW'(1);
    assign head     = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= in_entry;
        end else if (overrun && !empty) begin
            mem[newest].ovr <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok)  wptr <= ptr_inc(wptr);
            if (pop_done) rptr <= ptr_inc(rptr);
            case ({push_ok, pop_done})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CAP_FIFO);

    p_ovr_drops_r4: assert property (@(posedge clk) disable iff (rst)
        (overrun && !pop_done) |=> (count == $past(count)));

    p_full_both_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pop_done && count == cap) |=> (count == $past(count)));

endmodule

// File: rtl/rxcap_status.sv
module rxcap_status
    import rxcap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pop_done,
    input  rx_err_t pop_err,
    input  logic    overrun,
    input  logic    clr,
    output rx_err_t stat
);
    rx_err_t stat_nx;

    always_comb begin
        stat_nx = stat;
        if (clr) stat_nx = '0;
        if (pop_done) begin
            stat_nx.frm = pop_err.frm;
            stat_nx.par = pop_err.par;
            stat_nx.brk = pop_err.brk;
        end
        if (overrun) stat_nx.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= stat_nx;
    end

    p_ovr_sets_r5: assert property (@(posedge clk) disable iff (rst)
        overrun |=> stat.ovr);

    p_feb_only_on_read_r6: assert property (@(posedge clk) disable iff (rst)
        (!pop_done && !clr) |=> $stable({stat.brk, stat.par, stat.frm}));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !pop_done && !overrun) |=> (stat == '0));

    p_ovr_beats_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (clr && overrun) |=> stat.ovr);

endmodule

// File: rtl/rxcap_rx_capture.sv
module rxcap_rx_capture
    import rxcap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fifo_en,
    input  logic        rx_valid,
    input  logic [7:0]  rx_char,
    input  logic        rx_frame_err,
    input  logic        rx_parity_err,
    input  logic        rx_break_err,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        bus_sel,
    output logic [11:0] bus_rdata,
    output logic        rx_empty,
    output logic        rx_full
);
    rx_entry_t in_entry, head, last_q;
    rx_err_t   stat;
    logic      pop_req, pop_done, overrun, clr;
    logic [ENTRY_W-1:0] rdata_q;

    assign in_entry = make_entry(rx_char, rx_frame_err, rx_parity_err, rx_break_err);
    assign pop_req  = bus_rd && (bus_sel_t'(bus_sel) == SEL_DATA);
    assign clr      = bus_wr && (bus_sel_t'(bus_sel) == SEL_STAT);

    rxcap_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .fifo_en  (fifo_en),
        .in_valid (rx_valid),
        .in_entry (in_entry),
        .pop_req  (pop_req),
        .head     (head),
        .empty    (rx_empty),
        .full     (rx_full),
        .pop_done (pop_done),
        .overrun  (overrun)
    );

    rxcap_status u_status (
        .clk      (clk),
        .rst      (rst),
        .pop_done (pop_done),
        .pop_err  (err_of(head)),
        .overrun  (overrun),
        .clr      (clr),
        .stat     (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (pop_done) last_q <= head;
            if (bus_rd) begin
                if (bus_sel_t'(bus_sel) == SEL_STAT)
                    rdata_q <= {{(ENTRY_W - ERR_W){1'b0}}, stat};
                else if (pop_done)
                    rdata_q <= head;
                else
                    rdata_q <= last_q;
            end
        end
    end

    assign bus_rdata = rdata_q;

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(rx_empty && rx_full));

    p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_sel && rx_empty && !rx_valid) |=>
            (bus_rdata == $past(last_q)) && rx_empty);

endmodule

// File: tb/test_rxcap_rx_capture.sv
`timescale 1ns/1ps
module test_rxcap_rx_capture;

    logic        clk = 1'b0;
    logic        rst;
    logic        fifo_en;
    logic        rx_valid;
    logic [7:0]  rx_char;
    logic        rx_frame_err, rx_parity_err, rx_break_err;
    logic        bus_rd, bus_wr, bus_sel;
    logic [11:0] bus_rdata;
    logic        rx_empty, rx_full;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rxcap_rx_capture #(.DEPTH(16)) i_rxcap_rx_capture (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .rx_break_err(rx_break_err),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_rdata(bus_rdata), .rx_empty(rx_empty), .rx_full(rx_full)
    );

    // op: 0 push, 1 data read, 2 status read, 3 status write
    // {op[1:0], payload[10:0] = {brk,par,frm,char}, exp_rdata[11:0], pad, exp_empty, exp_full}
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {2'd0, 11'h041, 12'h000, 1'b0, 1'b0, 1'b1},   // R3 one entry fills
        {2'd1, 11'h000, 12'h041, 1'b0, 1'b1, 1'b0},   // R1
        {2'd0, 11'h15A, 12'h000, 1'b0, 1'b0, 1'b1},
        {2'd2, 11'h000, 12'h000, 1'b0, 1'b0, 1'b1},   // R6 not yet mirrored
        {2'd1, 11'h000, 12'h15A, 1'b0, 1'b1, 1'b0},   // R1 framing at bit 8
        {2'd2, 11'h000, 12'h001, 1'b0, 1'b1, 1'b0},   // R6
        {2'd0, 11'h633, 12'h000, 1'b0, 1'b0, 1'b1},
        {2'd0, 11'h077, 12'h000, 1'b0, 1'b0, 1'b1},   // R4 overrun
        {2'd2, 11'h000, 12'h009, 1'b0, 1'b0, 1'b1},   // R5
        {2'd1, 11'h000, 12'hE33, 1'b0, 1'b1, 1'b0},   // R4 bit 11 on entry
        {2'd2, 11'h000, 12'h00E, 1'b0, 1'b1, 1'b0},   // R6
        {2'd3, 11'h000, 12'h000, 1'b0, 1'b1, 1'b0},   // R7
        {2'd2, 11'h000, 12'h000, 1'b0, 1'b1, 1'b0},   // R7
        {2'd1, 11'h000, 12'hE33, 1'b0, 1'b1, 1'b0}    // R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_sel = 1'b0;
        rx_char = 8'h00; rx_frame_err = 1'b0; rx_parity_err = 1'b0; rx_break_err = 1'b0;
    endtask

    task automatic set_push(input logic [10:0] p);
        rx_valid = 1'b1; rx_char = p[7:0];
        rx_frame_err = p[8]; rx_parity_err = p[9]; rx_break_err = p[10];
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    function automatic logic [10:0] fifo_pl(input int i);
        logic [7:0] c;
        c = 8'(i * 13 + 5);
        return {i[2], i[1], i[0], c};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        fifo_en = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk("R9 empty", rx_empty, 1);
        chk("R9 full", rx_full, 0);
        chk("R9 rdata", bus_rdata, 0);
        bus_rd = 1'b1; bus_sel = 1'b1;
        step();
        chk("R9 status", bus_rdata, 0);

        // character-mode vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0] op;
            op = VEC[v][27:26];
            case (op)
                2'd0: set_push(VEC[v][25:15]);
                2'd1: begin bus_rd = 1'b1; bus_sel = 1'b0; end
                2'd2: begin bus_rd = 1'b1; bus_sel = 1'b1; end
                default: begin bus_wr = 1'b1; bus_sel = 1'b1; end
            endcase
            step();
            if (op == 2'd1 || op == 2'd2)
                chk($sformatf("R1/R4/R5/R6/R7/R8 vector %0d rdata", v), bus_rdata, VEC[v][14:3]);
            chk($sformatf("R3 vector %0d empty", v), rx_empty, VEC[v][1]);
            chk($sformatf("R3 vector %0d full", v), rx_full, VEC[v][0]);
        end

        // R11 overrun together with status write
        set_push(11'h0A5);
        step();
        set_push(11'h0B6);
        bus_wr = 1'b1; bus_sel = 1'b1;
        step();
        bus_rd = 1'b1; bus_sel = 1'b1;
        step();
        chk("R11 status ovr", bus_rdata, 12'h008);
        bus_rd = 1'b1; bus_sel = 1'b0;
        step();
        chk("R11 entry ovr", bus_rdata, 12'h8A5);
        bus_wr = 1'b1; bus_sel = 1'b1;
        step();

        // R2 FIFO mode order and depth
        fifo_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            set_push(fifo_pl(i));
            step();
            if (i == 14) chk("R2 full at 15", rx_full, 0);
        end
        chk("R2 full at 16", rx_full, 1);

        // R10 read and arrival in the same cycle while full
        set_push(11'h0C4);
        bus_rd = 1'b1; bus_sel = 1'b0;
        step();
        chk("R10 first entry", bus_rdata, {1'b0, fifo_pl(0)});
        chk("R10 still full", rx_full, 1);
        bus_rd = 1'b1; bus_sel = 1'b1;
        step();
        chk("R10 no overrun", bus_rdata[3], 0);
        for (int i = 1; i < 16; i++) begin
            bus_rd = 1'b1; bus_sel = 1'b0;
            step();
            chk($sformatf("R2 order %0d", i), bus_rdata, {1'b0, fifo_pl(i)});
        end
        bus_rd = 1'b1; bus_sel = 1'b0;
        step();
        chk("R10 arrival last", bus_rdata, 12'h0C4);
        chk("R2 empty after drain", rx_empty, 1);
        bus_rd = 1'b1; bus_sel = 1'b0;
        step();
        chk("R8 empty read holds", bus_rdata, 12'h0C4);
        chk("R8 still empty", rx_empty, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule